// File: doc/BRIEF.md
# Descriptor Pointer Sequencer

This block keeps the current descriptor pointers of a scatter-gather DMA channel and fetches the descriptors they point to. There are two pointers, one for the source side and one for the destination side. Each is a 49-bit byte address, built from a 32-bit low part and a 17-bit high part. A descriptor is four 32-bit words. It carries a payload address, a byte count and a flag word with the coherent, chain-type and interrupt bits. On the source side the flag word also holds a two-bit command. The payload transfer itself happens elsewhere. This block only supplies the decoded descriptor and moves the pointers along the chain.

A request names a side and says either "fetch at the current pointer" or "advance, then fetch". The advance step depends on the type bit of the last descriptor fetched on that side. A linear chain (type 0) steps the pointer by the descriptor size, 16 bytes. A linked chain (type 1) loads the pointer from the 64-bit word that sits just after the current descriptor. A fetch from an address that is not on a 16-byte boundary produces an all-zero descriptor and raises sticky error flags, and no memory is read. In register-pointer mode the descriptor comes straight from programmable words and memory is never touched. In memory mode the payload logic can also signal that the destination descriptor is used up, which advances the destination pointer and fetches the next descriptor.

Top module: `dps_seq`

## Requirements
- R1: After reset both pointers are zero, and busy, mem_req, desc_valid, err_flag, src_rd_err and dst_rd_err are all low.
- R2: start_load sampled while idle copies src_start and dst_start into the two pointers and clears err_flag, src_rd_err and dst_rd_err. While busy it is ignored. Errors stay set until such a load.
- R3: A memory-mode fetch reads the words at pointer+0, +4, +8 and +12. The decoded fields are: desc_addr = {word1[16:0], word0}; desc_size = word2[29:0]; desc_coh = word3 bit0; desc_type = word3 bit1; desc_intr = word3 bit2; desc_cmd = word3 bits 4..3 on the source side (desc_side=0) and zero on the destination side (desc_side=1).
- R4: An advance on a side whose last fetched descriptor had type 0 (or on which nothing has been fetched since reset or start_load) sets that pointer to pointer+16. It then fetches there with 4 reads.
- R5: An advance on a side whose last descriptor had type 1 reads pointer+16 (low half) and then pointer+20 (high half). The pointer becomes {high[16:0], low} only after both words return. Then 4 fetch reads follow.
- R6: A fetch at a pointer with bits 3..0 not all zero issues no read. It returns desc_err=1 with all fields zero, and sets err_flag and that side's read-error bit (src_rd_err or dst_rd_err).
- R7: With ptr_mode_mem=0 a request delivers the side's register words (reg_src_desc or reg_dst_desc, word i at bits 32i+31..32i) with desc_valid in the cycle after acceptance. It makes no memory read and leaves both pointers unchanged, even on an advance.
- R8: In memory mode, dst_empty sampled while idle with no cmd_valid acts as an advance-and-fetch on the destination side. In register mode dst_empty has no effect.
- R9: busy rises the cycle after a memory-mode request is accepted and falls at the edge that captures the last descriptor word. desc_valid pulses for exactly that one cycle. Requests arriving while busy are dropped.
- R10: mem_req holds, with a stable word-aligned mem_addr, until mem_rvalid returns the word. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_mode_mem | input | 1 | 1: descriptors come from memory; 0: from register words |
| start_load | input | 1 | Load both pointers from the start addresses and clear errors |
| src_start | input | 49 | Source chain start address |
| dst_start | input | 49 | Destination chain start address |
| reg_src_desc | input | 128 | Source descriptor register words |
| reg_dst_desc | input | 128 | Destination descriptor register words |
| cmd_valid | input | 1 | Request strobe |
| cmd_side | input | 1 | 0 source, 1 destination |
| cmd_advance | input | 1 | 1: advance the pointer before fetching |
| dst_empty | input | 1 | Destination descriptor exhausted |
| mem_req | output | 1 | Read request, held until answered |
| mem_addr | output | 49 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| src_ptr | output | 49 | Current source pointer |
| dst_ptr | output | 49 | Current destination pointer |
| desc_valid | output | 1 | One-cycle pulse: descriptor ready |
| desc_side | output | 1 | Side of the delivered descriptor |
| desc_err | output | 1 | Delivered descriptor was misaligned |
| desc_addr | output | 49 | Payload address |
| desc_size | output | 30 | Byte count |
| desc_cmd | output | 2 | Source command field |
| desc_intr | output | 1 | Interrupt-on-complete |
| desc_type | output | 1 | Chain type: 0 linear, 1 linked |
| desc_coh | output | 1 | Coherent flag |
| err_flag | output | 1 | Sticky error |
| src_rd_err | output | 1 | Sticky source descriptor read error |
| dst_rd_err | output | 1 | Sticky destination descriptor read error |

## Verification
The assertions watch the read handshake on every cycle: the request is held with a stable, word-aligned address until it is answered. They also check the busy/desc_valid relationship, that a misaligned fetch returns an all-zero descriptor, and that errors stay set until a start load. The choice between a linear and a linked advance, the order of the next-pointer halves, the field decoding on each side, and the register-mode and dst_empty paths depend on chain history and memory contents. Only the bench's scenarios can show those: a mixed linear and linked chain on both sides, a pointer with its top bit set, a misaligned link target, and requests sent while busy.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int DPS_ADDR_W   = 49;
  localparam int DPS_DATA_W   = 32;
  localparam int DPS_NWORDS   = 4;
  localparam int DPS_SIZE_W   = 30;
  localparam int DPS_NSIDES   = 2;
  localparam int DPS_TYPE_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NEXT  = 2'd1,
    ST_FETCH = 2'd2
  } dps_state_e;
endpackage

// File: rtl/dps_ptr_bank.sv
module dps_ptr_bank #(
  parameter int ADDR_W = 49,
  parameter int NSIDES = 2,
  localparam int SEL_W = (NSIDES > 1) ? $clog2(NSIDES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NSIDES*ADDR_W-1:0] start_flat,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_side,
  input  logic [ADDR_W-1:0]        wr_val,
  output logic [NSIDES*ADDR_W-1:0] ptr_flat
);
  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    logic [ADDR_W-1:0] ptr_q, ptr_d;

    always_comb begin
      ptr_d = ptr_q;
      if (load) begin
        ptr_d = start_flat[s*ADDR_W +: ADDR_W];
      end else if (wr_en && (wr_side == SEL_W'(s))) begin
        ptr_d = wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
    end

    assign ptr_flat[s*ADDR_W +: ADDR_W] = ptr_q;
  end
endmodule

// File: rtl/dps_desc_decode.sv
module dps_desc_decode #(
  parameter int ADDR_W   = 49,
  parameter int DW       = 32,
  parameter int NWORDS   = 4,
  parameter int SIZE_W   = 30,
  localparam int HI_W    = ADDR_W - DW
) (
  input  logic [NWORDS*DW-1:0] words_flat,
  input  logic                 side,
  output logic [ADDR_W-1:0]    f_addr,
  output logic [SIZE_W-1:0]    f_size,
  output logic [1:0]           f_cmd,
  output logic                 f_intr,
  output logic                 f_type,
  output logic                 f_coh
);
  logic [DW-1:0] w0, w1, w2, w3;
  logic          unused_bits;

  assign w0 = words_flat[0*DW +: DW];
  assign w1 = words_flat[1*DW +: DW];
  assign w2 = words_flat[2*DW +: DW];
  assign w3 = words_flat[3*DW +: DW];

  always_comb begin
    f_addr = {w1[HI_W-1:0], w0};
    f_size = w2[SIZE_W-1:0];
    f_coh  = w3[0];
    f_type = w3[1];
    f_intr = w3[2];
    // destination descriptors carry no command field
    f_cmd  = side ? 2'b00 : w3[4:3];
  end

  assign unused_bits = &{1'b0, w1[DW-1:HI_W], w2[DW-1:SIZE_W], w3[DW-1:5]};
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int ADDR_W   = 49,
  parameter int DW       = 32,
  parameter int NWORDS   = 4,
  parameter int TYPE_BIT = 1,
  localparam int HI_W       = ADDR_W - DW,
  localparam int DESC_BYTES = NWORDS * DW / 8,
  localparam int ALIGN_W    = $clog2(DESC_BYTES),
  localparam int WB_SH      = $clog2(DW / 8),
  localparam int CNT_W      = $clog2(NWORDS),
  localparam int FLAT_W     = NWORDS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_mode_mem,
  input  logic              start_load,
  input  logic [FLAT_W-1:0] reg_src_desc,
  input  logic [FLAT_W-1:0] reg_dst_desc,
  input  logic              cmd_valid,
  input  logic              cmd_side,
  input  logic              cmd_advance,
  input  logic              dst_empty,
  input  logic [ADDR_W-1:0] ptr_src,
  input  logic [ADDR_W-1:0] ptr_dst,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              ptr_load,
  output logic              ptr_wr,
  output logic              ptr_wr_side,
  output logic [ADDR_W-1:0] ptr_wr_val,
  output logic [FLAT_W-1:0] words_flat,
  output logic              d_side,
  output logic              d_valid,
  output logic              d_err,
  output logic              err_flag,
  output logic              src_err,
  output logic              dst_err
);
  dps_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              side_q, side_d;
  logic [DW-1:0]     lo_q, lo_d;
  logic [FLAT_W-1:0] words_q, words_d;
  logic              dvalid_q, dvalid_d;
  logic              derr_q, derr_d;
  logic              err_q, err_d;
  logic [1:0]        serr_q, serr_d;
  logic [1:0]        type_q, type_d;

  logic              idle, start_acc, go_cmd, go_empty, go, g_side, g_adv;
  logic [ADDR_W-1:0] cur_base, g_base, off_next;
  logic              misalign;

  assign idle      = (state_q == ST_IDLE);
  assign start_acc = idle && start_load;
  assign go_cmd    = idle && !start_load && cmd_valid;
  assign go_empty  = idle && !start_load && !cmd_valid && dst_empty && ptr_mode_mem;
  assign go        = go_cmd || go_empty;
  assign g_side    = go_cmd ? cmd_side : 1'b1;
  assign g_adv     = go_cmd ? cmd_advance : 1'b1;

  assign cur_base  = side_q ? ptr_dst : ptr_src;
  assign g_base    = g_side ? ptr_dst : ptr_src;
  assign misalign  = |cur_base[ALIGN_W-1:0];
  assign off_next  = (state_q == ST_NEXT) ? ADDR_W'(DESC_BYTES) : '0;

  assign mem_addr  = cur_base + off_next + (ADDR_W'(cnt_q) << WB_SH);
  assign mem_req   = (state_q == ST_NEXT) || ((state_q == ST_FETCH) && !misalign);
  assign busy      = !idle;
  assign ptr_load  = start_acc;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    side_d      = side_q;
    lo_d        = lo_q;
    words_d     = words_q;
    dvalid_d    = 1'b0;
    derr_d      = derr_q;
    err_d       = err_q;
    serr_d      = serr_q;
    type_d      = type_q;
    ptr_wr      = 1'b0;
    ptr_wr_side = side_q;
    ptr_wr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_acc) begin
          err_d  = 1'b0;
          serr_d = '0;
          type_d = '0;
        end else if (go) begin
          side_d = g_side;
          cnt_d  = '0;
          if (!ptr_mode_mem) begin
            words_d  = g_side ? reg_dst_desc : reg_src_desc;
            dvalid_d = 1'b1;
            derr_d   = 1'b0;
          end else if (g_adv && type_q[g_side]) begin
            state_d = ST_NEXT;
          end else begin
            state_d = ST_FETCH;
            if (g_adv) begin
              ptr_wr      = 1'b1;
              ptr_wr_side = g_side;
              ptr_wr_val  = g_base + ADDR_W'(DESC_BYTES);
            end
          end
        end
      end
      ST_NEXT: begin
        if (mem_rvalid) begin
          if (cnt_q == '0) begin
            lo_d  = mem_rdata;
            cnt_d = CNT_W'(1);
          end else begin
            ptr_wr     = 1'b1;
            ptr_wr_val = {mem_rdata[HI_W-1:0], lo_q};
            cnt_d      = '0;
            state_d    = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (misalign) begin
          words_d        = '0;
          dvalid_d       = 1'b1;
          derr_d         = 1'b1;
          err_d          = 1'b1;
          serr_d[side_q] = 1'b1;
          type_d[side_q] = 1'b0;
          state_d        = ST_IDLE;
        end else if (mem_rvalid) begin
          words_d[cnt_q*DW +: DW] = mem_rdata;
          if (cnt_q == CNT_W'(NWORDS - 1)) begin
            dvalid_d       = 1'b1;
            derr_d         = 1'b0;
            type_d[side_q] = mem_rdata[TYPE_BIT];
            cnt_d          = '0;
            state_d        = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      side_q   <= 1'b0;
      lo_q     <= '0;
      words_q  <= '0;
      dvalid_q <= 1'b0;
      derr_q   <= 1'b0;
      err_q    <= 1'b0;
      serr_q   <= '0;
      type_q   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      side_q   <= side_d;
      lo_q     <= lo_d;
      words_q  <= words_d;
      dvalid_q <= dvalid_d;
      derr_q   <= derr_d;
      err_q    <= err_d;
      serr_q   <= serr_d;
      type_q   <= type_d;
    end
  end

  assign words_flat = words_q;
  assign d_side     = side_q;
  assign d_valid    = dvalid_q;
  assign d_err      = derr_q;
  assign err_flag   = err_q;
  assign src_err    = serr_q[0];
  assign dst_err    = serr_q[1];

  // R9
  desc_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> !busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> d_valid);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R10
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[WB_SH-1:0] == '0));
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(start_load && !busy)) |=> err_flag);
endmodule

// File: rtl/dps_seq.sv
module dps_seq
  import dps_pkg::*;
#(
  parameter int ADDR_W   = DPS_ADDR_W,
  parameter int DW       = DPS_DATA_W,
  parameter int NWORDS   = DPS_NWORDS,
  parameter int SIZE_W   = DPS_SIZE_W,
  localparam int FLAT_W  = NWORDS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_mode_mem,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] src_start,
  input  logic [ADDR_W-1:0] dst_start,
  input  logic [FLAT_W-1:0] reg_src_desc,
  input  logic [FLAT_W-1:0] reg_dst_desc,
  input  logic              cmd_valid,
  input  logic              cmd_side,
  input  logic              cmd_advance,
  input  logic              dst_empty,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              desc_valid,
  output logic              desc_side,
  output logic              desc_err,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [SIZE_W-1:0] desc_size,
  output logic [1:0]        desc_cmd,
  output logic              desc_intr,
  output logic              desc_type,
  output logic              desc_coh,
  output logic              err_flag,
  output logic              src_rd_err,
  output logic              dst_rd_err
);
  logic                         ptr_load, ptr_wr, ptr_wr_side;
  logic [ADDR_W-1:0]            ptr_wr_val;
  logic [DPS_NSIDES*ADDR_W-1:0] ptr_flat;
  logic [FLAT_W-1:0]            words_flat;

  assign src_ptr = ptr_flat[0*ADDR_W +: ADDR_W];
  assign dst_ptr = ptr_flat[1*ADDR_W +: ADDR_W];

  dps_ptr_bank #(.ADDR_W(ADDR_W), .NSIDES(DPS_NSIDES)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ptr_load),
    .start_flat ({dst_start, src_start}),
    .wr_en      (ptr_wr),
    .wr_side    (ptr_wr_side),
    .wr_val     (ptr_wr_val),
    .ptr_flat   (ptr_flat)
  );

  dps_ctrl #(.ADDR_W(ADDR_W), .DW(DW), .NWORDS(NWORDS), .TYPE_BIT(DPS_TYPE_BIT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_mode_mem (ptr_mode_mem),
    .start_load   (start_load),
    .reg_src_desc (reg_src_desc),
    .reg_dst_desc (reg_dst_desc),
    .cmd_valid    (cmd_valid),
    .cmd_side     (cmd_side),
    .cmd_advance  (cmd_advance),
    .dst_empty    (dst_empty),
    .ptr_src      (src_ptr),
    .ptr_dst      (dst_ptr),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .busy         (busy),
    .ptr_load     (ptr_load),
    .ptr_wr       (ptr_wr),
    .ptr_wr_side  (ptr_wr_side),
    .ptr_wr_val   (ptr_wr_val),
    .words_flat   (words_flat),
    .d_side       (desc_side),
    .d_valid      (desc_valid),
    .d_err        (desc_err),
    .err_flag     (err_flag),
    .src_err      (src_rd_err),
    .dst_err      (dst_rd_err)
  );

  dps_desc_decode #(.ADDR_W(ADDR_W), .DW(DW), .NWORDS(NWORDS), .SIZE_W(SIZE_W)) u_dec (
    .words_flat (words_flat),
    .side       (desc_side),
    .f_addr     (desc_addr),
    .f_size     (desc_size),
    .f_cmd      (desc_cmd),
    .f_intr     (desc_intr),
    .f_type     (desc_type),
    .f_coh      (desc_coh)
  );

  // R6
  zero_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_err) |-> (desc_addr == '0 && desc_size == '0 &&
                                  !desc_type && !desc_intr && !desc_coh && desc_cmd == 2'b00));
endmodule

// File: tb/dps_seq_test.sv
`timescale 1ns/1ps
module dps_seq_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ptr_mode_mem, start_load, cmd_valid, cmd_side, cmd_advance, dst_empty;
  logic [48:0]  src_start, dst_start, mem_addr, src_ptr, dst_ptr, desc_addr;
  logic [127:0] reg_src_desc, reg_dst_desc;
  logic         mem_req, mem_rvalid, busy, desc_valid, desc_side, desc_err;
  logic [31:0]  mem_rdata;
  logic [29:0]  desc_size;
  logic [1:0]   desc_cmd;
  logic         desc_intr, desc_type, desc_coh, err_flag, src_rd_err, dst_rd_err;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [31:0] mem [256];

  always #4 clk = ~clk;

  dps_seq uut (
    .clk(clk), .rst_n(rst_n), .ptr_mode_mem(ptr_mode_mem), .start_load(start_load),
    .src_start(src_start), .dst_start(dst_start), .reg_src_desc(reg_src_desc),
    .reg_dst_desc(reg_dst_desc), .cmd_valid(cmd_valid), .cmd_side(cmd_side),
    .cmd_advance(cmd_advance), .dst_empty(dst_empty), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .desc_valid(desc_valid), .desc_side(desc_side),
    .desc_err(desc_err), .desc_addr(desc_addr), .desc_size(desc_size), .desc_cmd(desc_cmd),
    .desc_intr(desc_intr), .desc_type(desc_type), .desc_coh(desc_coh),
    .err_flag(err_flag), .src_rd_err(src_rd_err), .dst_rd_err(dst_rd_err)
  );

  typedef struct packed {
    logic        side;
    logic        adv;
    logic        empty;
    logic [3:0]  reads;
    logic [48:0] ptr;
    logic [48:0] addr;
    logic [29:0] size;
    logic [4:0]  flags;   // {cmd, intr, type, coh}
    logic        err;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 4'd4, 49'h100,            49'h1_FFFF_A000_0000, 30'h40,       5'b01101, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd4, 49'h110,            49'h1111,             30'h3FFFFFFF, 5'b10010, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd6, 49'h1_0000_0000_0200, 49'h1_0000_2222,    30'h20,       5'b00010, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd4, 49'h180,            49'h3333,             30'h80,       5'b00111, 1'b0},
    '{1'b1, 1'b1, 1'b1, 4'd6, 49'h1C0,            49'h4444,             30'h8,        5'b00000, 1'b0},
    '{1'b1, 1'b1, 1'b1, 4'd4, 49'h1D0,            49'h5555,             30'h10,       5'b00000, 1'b0},
    '{1'b0, 1'b1, 1'b0, 4'd2, 49'h308,            49'h0,                30'h0,        5'b00000, 1'b1}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      4: return "R8";
      5: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    mem[a[9:2]] = d;
  endtask

  task automatic issue(input logic s, input logic a, input logic e);
    @(negedge clk);
    rd_count = 0;
    if (e) dst_empty = 1'b1;
    else begin cmd_valid = 1'b1; cmd_side = s; cmd_advance = a; end
    @(negedge clk);
    cmd_valid = 1'b0;
    dst_empty = 1'b0;
  endtask

  task automatic wait_desc(output bit got);
    got = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (desc_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic do_start(input logic [48:0] s, input logic [48:0] d);
    @(negedge clk);
    src_start = s; dst_start = d; start_load = 1'b1;
    @(negedge clk);
    start_load = 1'b0;
  endtask

  // memory responder: one word answered per request, one cycle later
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr[9:2]];
        rd_count++;
      end else begin
        mem_rvalid = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int seen;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    wr(10'h100, 32'hA000_0000); wr(10'h104, 32'hFFFF_FFFF); wr(10'h108, 32'h40);       wr(10'h10C, 32'h0D);
    wr(10'h110, 32'h1111);      wr(10'h114, 32'h0);         wr(10'h118, 32'hFFFF_FFFF); wr(10'h11C, 32'h12);
    wr(10'h120, 32'h200);       wr(10'h124, 32'hFFFF_0000);
    wr(10'h200, 32'h2222);      wr(10'h204, 32'h1);         wr(10'h208, 32'h20);       wr(10'h20C, 32'h2);
    wr(10'h210, 32'h308);       wr(10'h214, 32'h0);
    wr(10'h180, 32'h3333);      wr(10'h188, 32'h80);        wr(10'h18C, 32'h1F);
    wr(10'h190, 32'h1C0);       wr(10'h194, 32'h0);
    wr(10'h1C0, 32'h4444);      wr(10'h1C8, 32'h8);         wr(10'h1CC, 32'h0);
    wr(10'h1D0, 32'h5555);      wr(10'h1D8, 32'h10);        wr(10'h1DC, 32'h0);

    rst_n = 1'b0; ptr_mode_mem = 1'b1; start_load = 1'b0; cmd_valid = 1'b0;
    cmd_side = 1'b0; cmd_advance = 1'b0; dst_empty = 1'b0;
    src_start = '0; dst_start = '0; reg_src_desc = '0; reg_dst_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "desc_valid", desc_valid, 0);
    chk("R1", "src_ptr", src_ptr, 0);
    chk("R1", "dst_ptr", dst_ptr, 0);
    chk("R1", "errors", {err_flag, src_rd_err, dst_rd_err}, 0);

    do_start(49'h100, 49'h180);
    chk("R2", "src_ptr load", src_ptr, 49'h100);
    chk("R2", "dst_ptr load", dst_ptr, 49'h180);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].side, VECS[i].adv, VECS[i].empty);
      wait_desc(got);
      chk(vtag(i), "desc_valid seen", got, 1);
      chk("R9", "busy at desc_valid", busy, 0);
      chk(vtag(i), "reads", rd_count, VECS[i].reads);
      chk(vtag(i), "pointer", VECS[i].side ? dst_ptr : src_ptr, VECS[i].ptr);
      chk("R3", "side", desc_side, VECS[i].side);
      chk("R3", "addr", desc_addr, VECS[i].addr);
      chk("R3", "size", desc_size, VECS[i].size);
      chk("R3", "flags", {desc_cmd, desc_intr, desc_type, desc_coh}, VECS[i].flags);
      chk(vtag(i), "desc_err", desc_err, VECS[i].err);
      @(negedge clk);
      chk("R9", "desc_valid one cycle", desc_valid, 0);
    end

    // R6 sticky error bits after misaligned source fetch
    chk("R6", "err_flag", err_flag, 1);
    chk("R6", "src_rd_err", src_rd_err, 1);
    chk("R6", "dst_rd_err", dst_rd_err, 0);

    // R2 load clears errors
    do_start(49'h100, 49'h180);
    chk("R2", "errors cleared", {err_flag, src_rd_err, dst_rd_err}, 0);
    chk("R2", "src_ptr reload", src_ptr, 49'h100);

    // R9 busy and requests dropped while busy; R2 load ignored while busy
    @(negedge clk);
    rd_count = 0;
    cmd_valid = 1'b1; cmd_side = 1'b0; cmd_advance = 1'b0;
    @(negedge clk);
    chk("R9", "busy after accept", busy, 1);
    cmd_valid = 1'b1; cmd_side = 1'b1; cmd_advance = 1'b1;
    start_load = 1'b1; src_start = 49'h40; dst_start = 49'h40;
    @(negedge clk);
    cmd_valid = 1'b0; start_load = 1'b0;
    wait_desc(got);
    chk("R9", "desc_valid seen", got, 1);
    chk("R9", "side of first request", desc_side, 0);
    chk("R10", "reads", rd_count, 4);
    chk("R2", "src_ptr unchanged by busy load", src_ptr, 49'h100);
    chk("R2", "dst_ptr unchanged by busy load", dst_ptr, 49'h180);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (desc_valid) seen++;
    end
    chk("R9", "dropped request produced descriptor", seen, 0);

    // R7 register mode
    ptr_mode_mem = 1'b0;
    reg_src_desc = {32'h0000_000B, 32'hC000_0123, 32'h0002_0001, 32'h6666};
    reg_dst_desc = {32'h0000_001F, 32'h55, 32'h0, 32'h7777};
    issue(1'b0, 1'b1, 1'b0);
    chk("R7", "desc_valid next cycle", desc_valid, 1);
    chk("R7", "addr", desc_addr, 49'h1_0000_6666);
    chk("R7", "size", desc_size, 30'h123);
    chk("R7", "flags", {desc_cmd, desc_intr, desc_type, desc_coh}, 5'b01011);
    chk("R7", "no reads", rd_count, 0);
    chk("R7", "src_ptr unchanged", src_ptr, 49'h100);
    issue(1'b1, 1'b0, 1'b0);
    chk("R7", "dst size", desc_size, 30'h55);
    chk("R3", "dst cmd zero", desc_cmd, 2'b00);

    // R8 dst_empty ignored in register mode
    issue(1'b0, 1'b0, 1'b1);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      if (desc_valid) seen++;
      @(negedge clk);
    end
    chk("R8", "no descriptor in register mode", seen, 0);
    chk("R8", "dst_ptr unchanged", dst_ptr, 49'h180);
    chk("R8", "no reads", rd_count, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule